// File: doc/BRIEF.md
# Storage Key Protection Unit

This unit keeps a protection key for every 2 KiB block of physical memory and checks each memory access against it. A requester presents a 4-bit access key along with an address and a store or fetch indication. The unit reads the entry of the addressed block and raises a protection exception in the same cycle when the keys conflict. On a permitted access, it records at the next clock edge that the block was referenced and, for a store, that it was changed.

A privileged command port lets supervisor logic work on any entry. It can read the entry, overwrite the whole entry, or read the reference bit and clear it in one atomic step. The unit does not perform address translation, carry memory data, or handle exceptions. It only delivers the exception flag and the key state.

Top module: `skey_guard`

## Requirements
- R1: The block index is the physical address with its low 11 bits dropped. Every byte inside one 2 KiB block uses the same entry, and addresses 0x7FF and 0x800 use different entries.
- R2: An entry is 8 bits wide: key in bits 3:0, fetch-protect flag in bit 4, reference bit in bit 5, change bit in bit 6. Bit 7 is never stored and always reads 0.
- R3: An access key of 0 never raises a protection exception, whatever the entry holds.
- R4: A store with a non-zero access key that differs from the entry key raises a protection exception.
- R5: When the fetch-protect flag is 0, a fetch never raises a protection exception.
- R6: When the fetch-protect flag is 1, a fetch raises a protection exception under the same key-mismatch rule as a store.
- R7: A permitted access sets the reference bit of its block. A permitted store also sets the change bit.
- R8: Command op 2'b10 (reset reference) returns the old reference bit on cmd_cc_o and clears that bit. It changes no other bit.
- R9: Command op 2'b01 (set key) writes bits 6:0 of cmd_wdata_i into the entry. Software can clear the reference and change bits this way. Ops 2'b00 (insert key) and 2'b11 only read the entry. cmd_rdata_o holds the entry while cmd_valid_i is high and is 0 otherwise. cmd_cc_o is 0 for every op other than reset reference.
- R10: An access that raises a protection exception leaves its block's entry unchanged.
- R11: acc_exc_o is valid in the cycle of the request. Status bit updates become visible only after the next rising clock edge.
- R12: When a set-key or reset-reference command and an access target the same block in the same cycle, the command result is written. The access status update is dropped, and the access is checked against the entry as it was before the command.
- R13: After reset every entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request present |
| acc_addr_i | input | ADDR_W | Physical address of the access |
| acc_store_i | input | 1 | 1 = store, 0 = fetch (instruction or operand) |
| acc_key_i | input | 4 | Requester access key |
| acc_exc_o | output | 1 | Protection exception for the current request |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 00 insert, 01 set, 10 reset reference, 11 read only |
| cmd_addr_i | input | ADDR_W | Physical address selecting the entry |
| cmd_wdata_i | input | 8 | Entry value for set key |
| cmd_rdata_o | output | 8 | Entry value before the command |
| cmd_cc_o | output | 1 | Old reference bit for reset reference |

## Verification
The bench aims at the 2 KiB boundary. A design that took one address bit too many or too few would hit the wrong entry and report an exception against a block that was never keyed. It checks that key zero passes against protected blocks, and that a fetch passes when the fetch-protect flag is clear but is checked when the flag is set. A design that mixes up those cases would either trap legitimate fetches or miss real violations. It also aims at reset reference run twice in a row, which must return 1 and then 0. Finally, it drives a set key and an access to the same block in one cycle: a design with the wrong priority would leave stray reference or change bits behind, or would check the access against the new key.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef struct packed {
    logic       chg;
    logic       ref_b;
    logic       fprot;
    logic [3:0] key;
  } skey_t;

  typedef enum logic [1:0] {
    OP_INSERT = 2'b00,
    OP_SET    = 2'b01,
    OP_RRB    = 2'b10,
    OP_READ   = 2'b11
  } skey_op_e;
endpackage

// File: rtl/skey_check.sv
module skey_check
  import skey_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       store_i,
  input  logic [3:0] key_i,
  input  skey_t      ent_i,
  output logic       exc_o
);
  logic mismatch;

  assign mismatch = (key_i != 4'd0) && (key_i != ent_i.key);
  assign exc_o    = valid_i && mismatch && (store_i || ent_i.fprot);

  assert_key0_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && key_i == 4'd0) |-> !exc_o);

  assert_fetch_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !store_i && !ent_i.fprot) |-> !exc_o);
endmodule

// File: rtl/skey_cmd.sv
module skey_cmd
  import skey_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic [7:0] wdata_i,
  input  skey_t      cur_i,
  output logic       wr_en_o,
  output skey_t      wr_data_o,
  output logic [7:0] rdata_o,
  output logic       cc_o
);
  skey_op_e op;
  assign op = skey_op_e'(op_i);

  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = cur_i;
    cc_o      = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_SET: begin
          wr_en_o   = 1'b1;
          wr_data_o = skey_t'(wdata_i[6:0]);
        end
        OP_RRB: begin
          wr_en_o         = 1'b1;
          wr_data_o.ref_b = 1'b0;
          cc_o            = cur_i.ref_b;
        end
        default: ;
      endcase
    end
  end

  assign rdata_o = valid_i ? {1'b0, cur_i} : 8'h00;
endmodule

// File: rtl/skey_array.sv
module skey_array
  import skey_pkg::*;
#(
  parameter int IDX_W   = 9,
  parameter int NUM_BLK = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_c_idx_i,
  output skey_t            rd_a_o,
  output skey_t            rd_c_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  skey_t            wr_data_i,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_store_i
);
  skey_t mem_w [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_ent
    skey_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        ent_q <= wr_data_i;  // command wins over access update
      end else if (upd_en_i && upd_idx_i == IDX_W'(g)) begin
        ent_q.ref_b <= 1'b1;
        ent_q.chg   <= ent_q.chg | upd_store_i;
      end
    end
    assign mem_w[g] = ent_q;
  end

  assign rd_a_o = mem_w[rd_a_idx_i];
  assign rd_c_o = mem_w[rd_c_idx_i];

  assert_set_whole_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_w[$past(wr_idx_i)] == $past(wr_data_i));

  assert_ref_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !(wr_en_i && wr_idx_i == upd_idx_i)) |=> mem_w[$past(upd_idx_i)].ref_b);
endmodule

// File: rtl/skey_guard.sv
module skey_guard
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_store_i,
  input  logic [3:0]        acc_key_i,
  output logic              acc_exc_o,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_wdata_i,
  output logic [7:0]        cmd_rdata_o,
  output logic              cmd_cc_o
);
  localparam int IDX_W   = ADDR_W - BLK_SHIFT;
  localparam int NUM_BLK = 1 << IDX_W;

  logic [IDX_W-1:0] aidx, cidx;
  skey_t            acc_ent, cmd_ent, cmd_wdata;
  logic             cmd_wr, upd_en;

  assign aidx   = acc_addr_i[ADDR_W-1:BLK_SHIFT];
  assign cidx   = cmd_addr_i[ADDR_W-1:BLK_SHIFT];
  assign upd_en = acc_valid_i && !acc_exc_o;

  skey_array #(.IDX_W(IDX_W), .NUM_BLK(NUM_BLK)) u_arr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_a_idx_i  (aidx),
    .rd_c_idx_i  (cidx),
    .rd_a_o      (acc_ent),
    .rd_c_o      (cmd_ent),
    .wr_en_i     (cmd_wr),
    .wr_idx_i    (cidx),
    .wr_data_i   (cmd_wdata),
    .upd_en_i    (upd_en),
    .upd_idx_i   (aidx),
    .upd_store_i (acc_store_i)
  );

  skey_check u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (acc_valid_i),
    .store_i (acc_store_i),
    .key_i   (acc_key_i),
    .ent_i   (acc_ent),
    .exc_o   (acc_exc_o)
  );

  skey_cmd u_cmd (
    .valid_i   (cmd_valid_i),
    .op_i      (cmd_op_i),
    .wdata_i   (cmd_wdata_i),
    .cur_i     (cmd_ent),
    .wr_en_o   (cmd_wr),
    .wr_data_o (cmd_wdata),
    .rdata_o   (cmd_rdata_o),
    .cc_o      (cmd_cc_o)
  );

  assert_rrb_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b10) |=> !u_arr.mem_w[$past(cidx)].ref_b);

  assert_exc_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_exc_o && !(cmd_wr && cidx == aidx))
      |=> u_arr.mem_w[$past(aidx)] == $past(acc_ent));
endmodule

// File: tb/skey_guard_tb_top.sv
module skey_guard_tb_top;
  localparam int ADDR_W = 20;
  localparam int SHIFT  = 11;
  localparam int NBLK   = 1 << (ADDR_W - SHIFT);

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              acc_valid_i, acc_store_i, cmd_valid_i;
  logic [ADDR_W-1:0] acc_addr_i, cmd_addr_i;
  logic [3:0]        acc_key_i;
  logic [1:0]        cmd_op_i;
  logic [7:0]        cmd_wdata_i, cmd_rdata_o;
  logic              acc_exc_o, cmd_cc_o;

  int checks = 0;
  int errors = 0;
  logic [6:0] mdl [NBLK];

  always #2 clk_i = ~clk_i;

  skey_guard #(.ADDR_W(ADDR_W), .BLK_SHIFT(SHIFT)) dut_i (.*);

  function automatic bit f_exc(logic [3:0] k, logic [6:0] e, bit st);
    return (k != 4'd0) && (k != e[3:0]) && (st || e[4]);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit av, int aaddr, bit ast, logic [3:0] akey,
                     bit cv, logic [1:0] op, int caddr, logic [7:0] wd);
    int  ai, ci;
    bit  e_exc, cwr;
    @(negedge clk_i);
    acc_valid_i = av; acc_addr_i = ADDR_W'(aaddr); acc_store_i = ast; acc_key_i = akey;
    cmd_valid_i = cv; cmd_op_i = op; cmd_addr_i = ADDR_W'(caddr); cmd_wdata_i = wd;
    ai = aaddr >> SHIFT; ci = caddr >> SHIFT;
    #1;
    e_exc = av && f_exc(akey, mdl[ai], ast);
    if (av) chk(tag, {7'd0, acc_exc_o}, {7'd0, e_exc});
    if (cv) begin
      chk(tag, cmd_rdata_o, {1'b0, mdl[ci]});
      chk(tag, {7'd0, cmd_cc_o}, {7'd0, (op == 2'b10) ? mdl[ci][5] : 1'b0});
    end else begin
      chk(tag, cmd_rdata_o, 8'h00);
    end
    @(posedge clk_i);
    cwr = cv && (op == 2'b01 || op == 2'b10);
    if (cv && op == 2'b01) mdl[ci] = wd[6:0];
    else if (cv && op == 2'b10) mdl[ci][5] = 1'b0;
    if (av && !e_exc && !(cwr && ci == ai)) begin
      mdl[ai][5] = 1'b1;
      if (ast) mdl[ai][6] = 1'b1;
    end
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, 0, 0, 0, 4'd0, 1, 2'b00, a, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NBLK; i++) mdl[i] = '0;
    rst_ni = 1'b0;
    acc_valid_i = 0; acc_addr_i = '0; acc_store_i = 0; acc_key_i = '0;
    cmd_valid_i = 0; cmd_op_i = '0; cmd_addr_i = '0; cmd_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R13 reset state
    rd("R13", 0); rd("R13", 5 << SHIFT); rd("R13", (NBLK - 1) << SHIFT);
    // R2 bit 7 not stored; R9 whole-entry write
    cyc("R2", 0, 0, 0, 0, 1, 2'b01, 12'h800, 8'hF3);
    rd("R2", 12'h800);
    cyc("R9", 0, 0, 0, 0, 1, 2'b01, 12'h800, 8'h03);
    rd("R9", 12'hFFF);
    // R1 boundary: 0x7FF is block 0, 0x800 is block 1
    cyc("R1", 1, 12'h7FF, 1, 4'd3, 0, 0, 0, 0);
    cyc("R1", 1, 12'h800, 1, 4'd3, 0, 0, 0, 0);
    rd("R7", 12'h800);
    rd("R10", 0);
    // R5 / R4 on unprotected-fetch block
    cyc("R5", 0, 0, 0, 0, 1, 2'b01, 2 << SHIFT, 8'h06);
    cyc("R5", 1, (2 << SHIFT) + 4, 0, 4'd9, 0, 0, 0, 0);
    rd("R7", 2 << SHIFT);
    cyc("R4", 1, (2 << SHIFT) + 8, 1, 4'd9, 0, 0, 0, 0);
    rd("R10", 2 << SHIFT);
    // R6 fetch-protected block
    cyc("R6", 0, 0, 0, 0, 1, 2'b01, 3 << SHIFT, 8'h16);
    cyc("R6", 1, 3 << SHIFT, 0, 4'd9, 0, 0, 0, 0);
    cyc("R6", 1, 3 << SHIFT, 0, 4'd6, 0, 0, 0, 0);
    cyc("R3", 1, 3 << SHIFT, 1, 4'd0, 0, 0, 0, 0);
    rd("R7", 3 << SHIFT);
    // R8 reset reference twice
    cyc("R8", 0, 0, 0, 0, 1, 2'b10, 3 << SHIFT, 8'h00);
    cyc("R8", 0, 0, 0, 0, 1, 2'b10, 3 << SHIFT, 8'h00);
    // R11 update not visible in same cycle
    cyc("R11", 1, 4 << SHIFT, 0, 4'd0, 1, 2'b00, 4 << SHIFT, 8'h00);
    rd("R11", 4 << SHIFT);
    // R12 command vs access on same block
    cyc("R12", 1, 5 << SHIFT, 1, 4'd0, 1, 2'b01, 5 << SHIFT, 8'h05);
    rd("R12", 5 << SHIFT);
    cyc("R12", 1, 5 << SHIFT, 0, 4'd5, 1, 2'b01, 5 << SHIFT, 8'h17);
    rd("R12", 5 << SHIFT);
    cyc("R12", 1, 5 << SHIFT, 1, 4'd0, 1, 2'b10, 5 << SHIFT, 8'h00);
    rd("R12", 5 << SHIFT);

    // random mix over a few blocks to force collisions
    for (int n = 0; n < 3000; n++) begin
      int ab, cb;
      logic [1:0] op;
      ab = int'($urandom_range(0, 7));
      cb = int'($urandom_range(0, 7));
      if (ab == 7) ab = NBLK - 1;
      op = 2'($urandom_range(0, 3));
      cyc((ab == cb) ? "R12" : "R7",
          1'($urandom_range(0, 1)), (ab << SHIFT) + int'($urandom_range(0, 2047)),
          1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)) & (($urandom_range(0, 3) == 0) ? 4'h0 : 4'hF),
          1'($urandom_range(0, 1)), op, (cb << SHIFT) + int'($urandom_range(0, 2047)),
          8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule